// File: doc/BRIEF.md
# Zigzag Scan Address Sequencer

This block walks a square tile of SIDE by SIDE cells in zigzag order and emits one cell coordinate per accepted cycle. It serves as the address source for a coefficient reorder stage: a consumer pulses `start`, then takes coordinates through a valid/ready handshake until the final corner cell arrives flagged with `last`.

The order does not come from a stored table. A small move program is computed from the program counter. It uses four primitive moves: step right, step down, diagonal up-right and diagonal down-left. The single-cell moves take one step each. A diagonal keeps stepping until it meets its stop condition, and it is also capped at SIDE steps.

The opening half starts with one step right. It then repeats a group of four moves: down-left diagonal, step down, up-right diagonal, step right. A down-left diagonal then crosses the main anti-diagonal. The closing half plays the opening group in mirrored order. In that half the diagonals stop against the far edges instead of the near ones, and a single step right finishes on the far corner. Coordinates are 1-based: x counts columns and y counts rows. A linear cell index is provided next to the coordinates.

Top module: `zz_scan_seq`

## Requirements
- R1: While `rst_n` is low, and after its release until a start, `valid` and `last` are low.
- R2: A `start` pulse while idle makes `valid` rise on the next clock edge, presenting x=1, y=1, index 0.
- R3: The accepted coordinates, SIDE*SIDE of them, follow zigzag order: the anti-diagonals x+y = const are visited in turn, and the row-major index sequence begins 0,1,SIDE,2*SIDE,SIDE+1,2. Each advance is one of (+1,0), (0,+1), (+1,-1) or (-1,+1). With `ready` held high, one coordinate is delivered per cycle.
- R4: `idx` equals (y-1)*SIDE + (x-1) for every presented coordinate.
- R5: Until the scan reaches (1,SIDE), which includes the crossing diagonal, an up-right diagonal stops when y reaches 1 and a down-left diagonal stops when x reaches 1.
- R6: After (1,SIDE), an up-right diagonal stops when x reaches SIDE and a down-left diagonal stops when y reaches SIDE. The mirrored move order is step right, up-right, step down, down-left, repeated, and the half ends with a single step right.
- R7: While `valid` is high and `ready` is low, `x`, `y` and `valid` hold their values.
- R8: `last` is high only on the coordinate (SIDE,SIDE). After that coordinate is accepted, `valid` is low on the next cycle and stays low until the next start.
- R9: A `start` pulse while `valid` is high is ignored: the scan neither restarts nor skips.
- R10: Every presented coordinate satisfies 1 <= x <= SIDE and 1 <= y <= SIDE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan when idle |
| ready | input | 1 | Consumer accepts the presented coordinate |
| valid | output | 1 | A coordinate is presented |
| last | output | 1 | Presented coordinate is the final corner |
| x | output | $clog2(SIDE+1) | Column, 1-based |
| y | output | $clog2(SIDE+1) | Row, 1-based |
| idx | output | $clog2(SIDE*SIDE) | Row-major cell index |

## Verification
The bench builds the block with SIDE=8, the standard 64-cell tile. With this size the opening half has three repetitions of the move group, which is enough to exercise every diagonal length from 1 to 7 and all four stop rules, including the switch of stop rules on the crossing diagonal. Every one of the 64 cells is compared against a zigzag order that the bench derives from anti-diagonal arithmetic. This is done once with `ready` held high and once with a periodic stall pattern combined with `start` pulses while busy, and a reset is also applied in the middle of a scan.

// File: rtl/zz_pkg.sv
package zz_pkg;

    typedef enum logic [1:0] {
        MV_RIGHT    = 2'd0,
        MV_DOWN     = 2'd1,
        MV_UP_RIGHT = 2'd2,
        MV_DN_LEFT  = 2'd3
    } zz_move_e;

endpackage

// File: rtl/zz_move_decode.sv
module zz_move_decode
    import zz_pkg::*;
#(
    parameter int SIDE = 8,
    parameter int PCW  = 5
) (
    input  logic [PCW-1:0] pc,
    output zz_move_e       move,
    output logic           mirrored
);
    localparam int REPS = SIDE / 2 - 1;
    localparam int HALF = 4 * REPS;

    logic [PCW-1:0] off_open;
    logic [PCW-1:0] off_close;

    always_comb begin
        off_open  = pc - PCW'(1);
        off_close = pc - PCW'(HALF + 2);
        move      = MV_RIGHT;
        mirrored  = 1'b0;
        if (pc == '0) begin
            move = MV_RIGHT;
        end else if (pc <= PCW'(HALF)) begin
            // opening group: down-left, down, up-right, right
            unique case (off_open[1:0])
                2'd0:    move = MV_DN_LEFT;
                2'd1:    move = MV_DOWN;
                2'd2:    move = MV_UP_RIGHT;
                default: move = MV_RIGHT;
            endcase
        end else if (pc == PCW'(HALF + 1)) begin
            // crossing diagonal still uses near-edge stop rules
            move = MV_DN_LEFT;
        end else if (pc <= PCW'(2 * HALF + 1)) begin
            mirrored = 1'b1;
            unique case (off_close[1:0])
                2'd0:    move = MV_RIGHT;
                2'd1:    move = MV_UP_RIGHT;
                2'd2:    move = MV_DOWN;
                default: move = MV_DN_LEFT;
            endcase
        end else begin
            mirrored = 1'b1;
            move     = MV_RIGHT;
        end
    end
endmodule

// File: rtl/zz_stepper.sv
module zz_stepper
    import zz_pkg::*;
#(
    parameter int SIDE = 8,
    parameter int CW   = 4,
    parameter int SCW  = 3
) (
    input  logic [CW-1:0]  cur_x,
    input  logic [CW-1:0]  cur_y,
    input  zz_move_e       move,
    input  logic           mirrored,
    input  logic [SCW-1:0] steps_done,
    output logic [CW-1:0]  nxt_x,
    output logic [CW-1:0]  nxt_y,
    output logic           move_done
);
    logic edge_hit;

    always_comb begin
        nxt_x    = cur_x;
        nxt_y    = cur_y;
        edge_hit = 1'b0;
        unique case (move)
            MV_RIGHT: begin
                nxt_x    = cur_x + CW'(1);
                edge_hit = 1'b1;
            end
            MV_DOWN: begin
                nxt_y    = cur_y + CW'(1);
                edge_hit = 1'b1;
            end
            MV_UP_RIGHT: begin
                nxt_x    = cur_x + CW'(1);
                nxt_y    = cur_y - CW'(1);
                edge_hit = mirrored ? (nxt_x == CW'(SIDE)) : (nxt_y == CW'(1));
            end
            default: begin
                nxt_x    = cur_x - CW'(1);
                nxt_y    = cur_y + CW'(1);
                edge_hit = mirrored ? (nxt_y == CW'(SIDE)) : (nxt_x == CW'(1));
            end
        endcase
        // step cap: this is the SIDE-th step of the move
        move_done = edge_hit || (steps_done == SCW'(SIDE - 1));
    end
endmodule

// File: rtl/zz_index.sv
module zz_index #(
    parameter int SIDE = 8,
    parameter int CW   = 4,
    parameter int IW   = 6
) (
    input  logic [CW-1:0] col,
    input  logic [CW-1:0] row,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] row0;
    logic [IW-1:0] col0;

    always_comb begin
        row0 = IW'(row - CW'(1));
        col0 = IW'(col - CW'(1));
        idx  = row0 * IW'(SIDE) + col0;
    end
endmodule

// File: rtl/zz_scan_seq.sv
module zz_scan_seq
    import zz_pkg::*;
#(
    parameter int SIDE = 8,
    localparam int CW    = $clog2(SIDE + 1),
    localparam int IW    = $clog2(SIDE * SIDE),
    localparam int MOVES = 8 * (SIDE / 2 - 1) + 3,
    localparam int PCW   = $clog2(MOVES + 1),
    localparam int SCW   = $clog2(SIDE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ready,
    output logic          valid,
    output logic          last,
    output logic [CW-1:0] x,
    output logic [CW-1:0] y,
    output logic [IW-1:0] idx
);
    generate
        if (SIDE < 4 || (SIDE % 2) != 0) begin : g_bad_side
            $error("zz_scan_seq: SIDE must be even and at least 4");
        end
    endgenerate

    typedef struct packed {
        logic           valid;
        logic [CW-1:0]  x;
        logic [CW-1:0]  y;
        logic [PCW-1:0] pc;
        logic [SCW-1:0] steps;
    } scan_state_t;

    scan_state_t s_d, s_q;

    zz_move_e      cur_move;
    logic          cur_mirrored;
    logic [CW-1:0] step_x;
    logic [CW-1:0] step_y;
    logic          step_done;
    logic          at_corner;

    zz_move_decode #(.SIDE(SIDE), .PCW(PCW)) u_decode (
        .pc       (s_q.pc),
        .move     (cur_move),
        .mirrored (cur_mirrored)
    );

    zz_stepper #(.SIDE(SIDE), .CW(CW), .SCW(SCW)) u_stepper (
        .cur_x      (s_q.x),
        .cur_y      (s_q.y),
        .move       (cur_move),
        .mirrored   (cur_mirrored),
        .steps_done (s_q.steps),
        .nxt_x      (step_x),
        .nxt_y      (step_y),
        .move_done  (step_done)
    );

    zz_index #(.SIDE(SIDE), .CW(CW), .IW(IW)) u_index (
        .col (s_q.x),
        .row (s_q.y),
        .idx (idx)
    );

    always_comb begin
        s_d       = s_q;
        at_corner = (s_q.x == CW'(SIDE)) && (s_q.y == CW'(SIDE));
        if (!s_q.valid) begin
            if (start) begin
                s_d.valid = 1'b1;
                s_d.x     = CW'(1);
                s_d.y     = CW'(1);
                s_d.pc    = '0;
                s_d.steps = '0;
            end
        end else if (ready) begin
            if (at_corner) begin
                s_d.valid = 1'b0;
            end else begin
                s_d.x = step_x;
                s_d.y = step_y;
                if (step_done) begin
                    s_d.pc    = s_q.pc + PCW'(1);
                    s_d.steps = '0;
                end else begin
                    s_d.steps = s_q.steps + SCW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid = s_q.valid;
    assign x     = s_q.x;
    assign y     = s_q.y;
    assign last  = s_q.valid && at_corner;

    // R2: idle start presents the origin
    p_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && start) |=> (valid && x == CW'(1) && y == CW'(1)));

    // R3: each accepted advance is one of the four primitive vectors
    p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && !last) |=> valid &&
        ((x == $past(x) + 1'b1 && y == $past(y)) ||
         (x == $past(x) && y == $past(y) + 1'b1) ||
         (x == $past(x) + 1'b1 && y == $past(y) - 1'b1) ||
         (x == $past(x) - 1'b1 && y == $past(y) + 1'b1)));

    // R7: stall holds the presented coordinate
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(x) && $stable(y)));

    // R8: accepting the final corner ends the scan
    p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && last) |=> !valid);

    // R9: start while busy does not reset the walk
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && start && !ready) |=> (valid && $stable(x) && $stable(y)));

    // R10: coordinates stay inside the tile
    p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (x >= CW'(1) && x <= CW'(SIDE) && y >= CW'(1) && y <= CW'(SIDE)));
endmodule

// File: tb/zz_scan_seq_tb.sv
module zz_scan_seq_tb;
    localparam int SIDE  = 8;
    localparam int NCELL = SIDE * SIDE;
    localparam int CW    = $clog2(SIDE + 1);
    localparam int IW    = $clog2(SIDE * SIDE);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ready = 1'b0;
    logic          valid;
    logic          last;
    logic [CW-1:0] x;
    logic [CW-1:0] y;
    logic [IW-1:0] idx;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    int  ref_x [NCELL];
    int  ref_y [NCELL];

    always #5 clk = ~clk;

    zz_scan_seq #(.SIDE(SIDE)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ready (ready),
        .valid (valid),
        .last  (last),
        .x     (x),
        .y     (y),
        .idx   (idx)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // zigzag order from anti-diagonal arithmetic, 0-based row r, column c
    task automatic build_ref();
        int k = 0;
        for (int s = 0; s <= 2 * SIDE - 2; s++) begin
            int lo = (s - SIDE + 1 > 0) ? s - SIDE + 1 : 0;
            int hi = (s < SIDE - 1) ? s : SIDE - 1;
            if (s % 2 == 0) begin
                for (int r = hi; r >= lo; r--) begin
                    ref_y[k] = r + 1; ref_x[k] = s - r + 1; k++;
                end
            end else begin
                for (int r = lo; r <= hi; r++) begin
                    ref_y[k] = r + 1; ref_x[k] = s - r + 1; k++;
                end
            end
        end
    endtask

    // mode 0: ready always high; mode 1: stalls plus start pulses while busy
    task automatic run_scan(input int mode);
        int  k = 0;
        int  cyc = 0;
        bit  stalled = 1'b0;
        int  hx = 0;
        int  hy = 0;
        string rq;
        @(negedge clk);
        start = 1'b1;
        ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(valid == 1'b1, "R2", "valid after start", int'(valid), 1);
        check(x == CW'(1) && y == CW'(1), "R2", "origin x*10+y", int'(x) * 10 + int'(y), 11);
        check(idx == '0, "R2", "origin idx", int'(idx), 0);
        while (k < NCELL && cyc < 4000) begin
            bit r;
            if (stalled) begin
                check(int'(x) == hx && int'(y) == hy, "R7", "held x*10+y",
                      int'(x) * 10 + int'(y), hx * 10 + hy);
                if (mode == 1 && (cyc % 11) == 5)
                    check(int'(x) == hx && int'(y) == hy, "R9", "start while busy x*10+y",
                          int'(x) * 10 + int'(y), hx * 10 + hy);
            end
            r = (mode == 0) ? 1'b1 : ((cyc % 5) != 3);
            ready = r;
            start = (mode == 1) && ((cyc % 11) == 4);
            if (!valid) begin
                check(1'b0, "R3", "valid dropped at cell", k, NCELL);
                k = NCELL;
            end else begin
                rq = (k < (SIDE * (SIDE + 1)) / 2) ? "R3/R5" : "R3/R6";
                check(x >= CW'(1) && x <= CW'(SIDE) && y >= CW'(1) && y <= CW'(SIDE),
                      "R10", "range x*10+y", int'(x) * 10 + int'(y), 11);
                if (r) begin
                    check(int'(x) == ref_x[k] && int'(y) == ref_y[k], rq, "coord x*10+y",
                          int'(x) * 10 + int'(y), ref_x[k] * 10 + ref_y[k]);
                    check(int'(idx) == (int'(y) - 1) * SIDE + int'(x) - 1, "R4", "idx",
                          int'(idx), (int'(y) - 1) * SIDE + int'(x) - 1);
                    check(last == (k == NCELL - 1), "R8", "last flag", int'(last),
                          int'(k == NCELL - 1));
                    stalled = 1'b0;
                    k++;
                end else begin
                    stalled = 1'b1;
                    hx = int'(x);
                    hy = int'(y);
                end
            end
            @(negedge clk);
            cyc++;
        end
        ready = 1'b0;
        start = 1'b0;
        if (mode == 0)
            check(cyc == NCELL, "R3", "cycles for full scan", cyc, NCELL);
        check(valid == 1'b0, "R8", "valid after final accept", int'(valid), 0);
        repeat (3) @(negedge clk);
        check(valid == 1'b0, "R8", "stays idle", int'(valid), 0);
    endtask

    initial begin
        build_ref();
        check(ref_x[2] == 1 && ref_y[2] == 2, "R3", "reference third cell", ref_x[2] * 10 + ref_y[2], 12);
        repeat (3) @(negedge clk);
        check(valid == 1'b0 && last == 1'b0, "R1", "valid|last in reset", int'(valid | last), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(valid == 1'b0, "R1", "start ignored in reset", int'(valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(valid == 1'b0, "R1", "idle after reset release", int'(valid), 0);

        run_scan(0);
        run_scan(1);

        // reset in the middle of a scan returns to idle
        start = 1'b1;
        ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(valid == 1'b0 && last == 1'b0, "R1", "valid after mid-scan reset", int'(valid), 0);
        rst_n = 1'b1;
        ready = 1'b0;
        @(negedge clk);
        run_scan(0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule